// File: doc/BRIEF.md
# SPI Write-Then-Read Transaction Engine

This block is an SPI master that performs one combined exchange per start request: a command phase of `tx_len` bytes taken from a valid/ready byte input, followed by a response phase of `rx_len` bytes. The whole exchange runs under a single chip-select assertion. During the command phase the bytes shifted in from the slave carry no information and are dropped. During the response phase the master shifts out zero bytes, and every byte it clocks in is presented on a byte output stream with a one-cycle valid strobe.

The serial clock comes from the system clock through two dividers: an even prescale value and a rate value. One serial clock period lasts `prescale * (1 + rate)` system clock cycles. An enable input gates the whole port. While it is low, chip select is held high, any exchange in flight is abandoned, and the output enable for the clock and data lines drops so that another master may use the bus.

Top module: `spi_wtr_engine`

## Requirements
- R1: `cs_n` falls once when a transaction with a non-zero total length starts. It stays low across every byte boundary and rises only after the last byte has been shifted. `busy` is high exactly while `cs_n` is low.
- R2: The number of bytes clocked on the bus equals `tx_len + rx_len`, and the transaction ends once that many bytes have been received.
- R3: The bytes received in the first `tx_len` slots are never presented. The bytes received in slots `tx_len` to `tx_len + rx_len - 1` appear on `rsp_data`, in order, one per `rsp_valid` pulse.
- R4: In slot i < `tx_len` the master sends the i-th byte accepted on `cmd_data` (a byte is accepted when `cmd_valid` and `cmd_ready` are both high at a clock edge). In every later slot it sends 0x00.
- R5: The frame is SPI mode 0 with 8-bit words, MSB first. `sclk` is low whenever `cs_n` is high. `mosi` changes only while `sclk` is low. The master samples `miso` on the rising edge of `sclk`.
- R6: The `sclk` period is `P * (1 + rate)` system clock cycles, where P is `prescale` with bit 0 cleared, and P is 2 when `prescale` is below 2. Divider values are captured at start.
- R7: When `en` is low, on the next clock `cs_n` is high, `bus_oe` is low, `sclk` and `mosi` are driven low, and `busy` is low. An exchange in progress is abandoned, and `start` has no effect.
- R8: `rsp_valid` pulses only for response-phase bytes of the current transaction. A partially received byte from an abandoned exchange is never presented, and a new transaction begins with an empty receiver.
- R9: A `start` pulse while `busy` is high is ignored: the lengths of the running exchange do not change. `done` pulses for one cycle on the clock at which `cs_n` is released.
- R10: With `tx_len` = 0 the first slot is already a zero filler. With both lengths 0, `done` pulses on the clock after `start` and `cs_n` never falls.
- R11: After reset, `cs_n` is high, `sclk` is low, and `busy`, `done`, `rsp_valid`, `cmd_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low parks the bus |
| start | input | 1 | Start pulse for one transaction |
| tx_len | input | LEN_W | Command byte count |
| rx_len | input | LEN_W | Response byte count |
| prescale | input | DIV_W | Even clock prescale, minimum 2 |
| rate | input | DIV_W | Serial clock rate divider minus one |
| cmd_data | input | 8 | Command byte |
| cmd_valid | input | 1 | Command byte valid |
| cmd_ready | output | 1 | Command byte accepted this cycle when valid |
| rsp_data | output | 8 | Response byte |
| rsp_valid | output | 1 | One-cycle strobe for rsp_data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| miso | input | 1 | Serial data from slave |
| bus_oe | output | 1 | Drive enable for sclk and mosi |

## Verification
The bench builds the block with LEN_W = 6 and DIV_W = 8. With these values, lengths up to 13 slots per exchange and divider settings from the smallest legal prescale up to 32 system cycles per bit all run within a short run time. The 8-bit divider width also admits an odd prescale, so the bench can check that bit 0 is dropped. The slave model answers a distinct byte in every slot, so a response taken from the wrong slot, a missing discard or an extra filler shows up as a mismatch.

// File: rtl/spi_wtr_pkg.sv
package spi_wtr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_XFER  = 2'd2
  } sq_state_t;
endpackage

// File: rtl/spi_wtr_clkgen.sv
// Half-period tick generator: one tick every (prescale/2)*(rate+1) cycles.
module spi_wtr_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] prescale,
  input  logic [DIV_W-1:0] rate,
  output logic             tick
);
  logic [DIV_W-1:0] half_pre;
  logic [DIV_W-1:0] pre_cnt;
  logic [DIV_W-1:0] rate_cnt;
  logic             pre_last;
  logic             rate_last;

  // bit 0 of the prescale is dropped; values below 2 behave as 2
  always_comb begin
    if (prescale < DIV_W'(2)) half_pre = DIV_W'(1);
    else                      half_pre = prescale >> 1;
  end

  assign pre_last  = (pre_cnt == half_pre - DIV_W'(1));
  assign rate_last = (rate_cnt == rate);
  assign tick      = run && pre_last && rate_last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else if (pre_last) begin
      pre_cnt <= '0;
      if (rate_last) rate_cnt <= '0;
      else           rate_cnt <= rate_cnt + DIV_W'(1);
    end else begin
      pre_cnt <= pre_cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_wtr_shift.sv
// Mode 0 byte shifter: sample on rising sclk, shift on falling sclk.
module spi_wtr_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         abort,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         tick,
  input  logic         miso,
  output logic         sclk,
  output logic         mosi,
  output logic         active,
  output logic         byte_done,
  output logic [W-1:0] rx_byte
);
  localparam int BC_W = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]    tx_sh;
  logic [W-1:0]    rx_sh;
  logic [BC_W-1:0] bit_cnt;
  logic            sclk_q;
  logic            active_q;
  logic            done_q;

  always_ff @(posedge clk) begin
    done_q <= 1'b0;
    if (rst || abort) begin
      tx_sh    <= '0;
      rx_sh    <= '0;
      bit_cnt  <= '0;
      sclk_q   <= 1'b0;
      active_q <= 1'b0;
    end else if (load) begin
      tx_sh    <= load_byte;
      rx_sh    <= '0;
      bit_cnt  <= '0;
      sclk_q   <= 1'b0;
      active_q <= 1'b1;
    end else if (active_q && tick) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
        rx_sh  <= {rx_sh[W-2:0], miso};
      end else begin
        sclk_q <= 1'b0;
        if (bit_cnt == BC_W'(W - 1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          tx_sh   <= {tx_sh[W-2:0], 1'b0};
          bit_cnt <= bit_cnt + BC_W'(1);
        end
      end
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = tx_sh[W-1];
  assign active    = active_q;
  assign byte_done = done_q;
  assign rx_byte   = rx_sh;
endmodule

// File: rtl/spi_wtr_seq.sv
// Transaction sequencer: slot counting, command fetch, filler and discard.
module spi_wtr_seq
  import spi_wtr_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int DIV_W = 8,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [DIV_W-1:0] prescale,
  input  logic [DIV_W-1:0] rate,
  input  logic [W-1:0]     cmd_data,
  input  logic             cmd_valid,
  input  logic             byte_done,
  input  logic [W-1:0]     rx_byte,
  output logic             cmd_ready,
  output logic [W-1:0]     rsp_data,
  output logic             rsp_valid,
  output logic             busy,
  output logic             done,
  output logic             cs_n,
  output logic             bus_oe,
  output logic             load,
  output logic [W-1:0]     load_byte,
  output logic [DIV_W-1:0] pre_q,
  output logic [DIV_W-1:0] rate_q
);
  localparam int CNT_W = LEN_W + 1;

  sq_state_t        st;
  logic [LEN_W-1:0] tx_q;
  logic [CNT_W-1:0] tot_q;
  logic [CNT_W-1:0] slot;
  logic [CNT_W-1:0] slot_nx;
  logic [CNT_W-1:0] tx_ext;
  logic [CNT_W-1:0] sum_len;

  assign slot_nx = slot + CNT_W'(1);
  assign tx_ext  = {1'b0, tx_q};
  assign sum_len = {1'b0, tx_len} + {1'b0, rx_len};

  always_ff @(posedge clk) begin
    done      <= 1'b0;
    rsp_valid <= 1'b0;
    load      <= 1'b0;
    if (rst) begin
      st        <= SQ_IDLE;
      tx_q      <= '0;
      tot_q     <= '0;
      slot      <= '0;
      cmd_ready <= 1'b0;
      rsp_data  <= '0;
      busy      <= 1'b0;
      cs_n      <= 1'b1;
      bus_oe    <= 1'b0;
      load_byte <= '0;
      pre_q     <= DIV_W'(2);
      rate_q    <= '0;
    end else if (!en) begin
      st        <= SQ_IDLE;
      cmd_ready <= 1'b0;
      busy      <= 1'b0;
      cs_n      <= 1'b1;
      bus_oe    <= 1'b0;
    end else begin
      bus_oe <= 1'b1;
      unique case (st)
        SQ_IDLE: begin
          if (start) begin
            tx_q   <= tx_len;
            tot_q  <= sum_len;
            slot   <= '0;
            pre_q  <= prescale;
            rate_q <= rate;
            if (sum_len == '0) begin
              done <= 1'b1;
            end else begin
              cs_n <= 1'b0;
              busy <= 1'b1;
              if (tx_len != '0) begin
                cmd_ready <= 1'b1;
                st        <= SQ_FETCH;
              end else begin
                load      <= 1'b1;
                load_byte <= '0;
                st        <= SQ_XFER;
              end
            end
          end
        end
        SQ_FETCH: begin
          if (cmd_ready && cmd_valid) begin
            cmd_ready <= 1'b0;
            load      <= 1'b1;
            load_byte <= cmd_data;
            st        <= SQ_XFER;
          end
        end
        SQ_XFER: begin
          if (byte_done) begin
            slot <= slot_nx;
            if (slot >= tx_ext) begin
              rsp_data  <= rx_byte;
              rsp_valid <= 1'b1;
            end
            if (slot_nx == tot_q) begin
              cs_n <= 1'b1;
              busy <= 1'b0;
              done <= 1'b1;
              st   <= SQ_IDLE;
            end else if (slot_nx < tx_ext) begin
              cmd_ready <= 1'b1;
              st        <= SQ_FETCH;
            end else begin
              load      <= 1'b1;
              load_byte <= '0;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_wtr_engine.sv
module spi_wtr_engine
  import spi_wtr_pkg::*;
#(
  parameter int LEN_W = 6,
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [DIV_W-1:0]  prescale,
  input  logic [DIV_W-1:0]  rate,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              rsp_valid,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              bus_oe
);
  logic              load;
  logic [BYTE_W-1:0] load_byte;
  logic [DIV_W-1:0]  pre_q;
  logic [DIV_W-1:0]  rate_q;
  logic              tick;
  logic              active;
  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              sclk_int;
  logic              mosi_int;

  spi_wtr_seq #(.LEN_W(LEN_W), .DIV_W(DIV_W), .W(BYTE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .start     (start),
    .tx_len    (tx_len),
    .rx_len    (rx_len),
    .prescale  (prescale),
    .rate      (rate),
    .cmd_data  (cmd_data),
    .cmd_valid (cmd_valid),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .cmd_ready (cmd_ready),
    .rsp_data  (rsp_data),
    .rsp_valid (rsp_valid),
    .busy      (busy),
    .done      (done),
    .cs_n      (cs_n),
    .bus_oe    (bus_oe),
    .load      (load),
    .load_byte (load_byte),
    .pre_q     (pre_q),
    .rate_q    (rate_q)
  );

  spi_wtr_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .run      (active),
    .prescale (pre_q),
    .rate     (rate_q),
    .tick     (tick)
  );

  spi_wtr_shift #(.W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .abort     (!en),
    .load      (load),
    .load_byte (load_byte),
    .tick      (tick),
    .miso      (miso),
    .sclk      (sclk_int),
    .mosi      (mosi_int),
    .active    (active),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  assign sclk = sclk_int & bus_oe;
  assign mosi = mosi_int & bus_oe;
endmodule

// File: rtl/spi_wtr_checks.sv
module spi_wtr_checks (
  input logic clk,
  input logic rst,
  input logic en,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sclk,
  input logic mosi,
  input logic bus_oe
);
  AST_BUSY_HOLDS_CS: assert property (@(posedge clk) disable iff (rst) busy |-> !cs_n); // R1
  AST_RSP_IN_TXN: assert property (@(posedge clk) disable iff (rst) rsp_valid |-> $past(busy)); // R8
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk); // R5
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst) (sclk && $past(sclk)) |-> $stable(mosi)); // R5
  AST_DISABLE_PARKS: assert property (@(posedge clk) disable iff (rst) !en |=> (cs_n && !bus_oe && !busy)); // R7
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst) done |-> (cs_n && !busy)); // R9
  AST_READY_IN_TXN: assert property (@(posedge clk) disable iff (rst) cmd_ready |-> busy); // R4
endmodule

bind spi_wtr_engine spi_wtr_checks u_checks (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .busy      (busy),
  .done      (done),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .mosi      (mosi),
  .bus_oe    (bus_oe)
);

// File: tb/spi_wtr_engine_test.sv
module spi_wtr_engine_test;
  localparam int LEN_W = 6;
  localparam int DIV_W = 8;
  localparam int NV    = 7;
  // fields: prescale, rate, tx_len, rx_len, flags (bit0 gap between cmd bytes, bit1 start poke while busy)
  localparam logic [39:0] VEC [NV] = '{
    {8'd2, 8'd0, 8'd1, 8'd2, 8'h00},
    {8'd4, 8'd1, 8'd4, 8'd2, 8'h02},
    {8'd2, 8'd2, 8'd0, 8'd3, 8'h00},
    {8'd6, 8'd0, 8'd3, 8'd0, 8'h01},
    {8'd2, 8'd0, 8'd5, 8'd8, 8'h01},
    {8'd8, 8'd3, 8'd1, 8'd1, 8'h00},
    {8'd3, 8'd0, 8'd1, 8'd1, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] tx_len = '0;
  logic [LEN_W-1:0] rx_len = '0;
  logic [DIV_W-1:0] prescale = 8'd2;
  logic [DIV_W-1:0] rate = '0;
  logic [7:0] cmd_data = '0;
  logic cmd_valid = 1'b0;
  logic cmd_ready, rsp_valid, busy, done, cs_n, sclk, mosi, bus_oe;
  logic [7:0] rsp_data;
  logic miso = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  spi_wtr_engine #(.LEN_W(LEN_W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst(rst), .en(en), .start(start), .tx_len(tx_len), .rx_len(rx_len),
    .prescale(prescale), .rate(rate), .cmd_data(cmd_data), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .rsp_data(rsp_data), .rsp_valid(rsp_valid), .busy(busy),
    .done(done), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso), .bus_oe(bus_oe)
  );

  function automatic logic [7:0] resp_of(input int slot);
    return (8'h5A + 8'(slot * 29)) ^ 8'(slot);
  endfunction

  // monitor and slave model, sampled on the falling system clock
  logic prev_sclk = 1'b0;
  logic prev_cs = 1'b1;
  int slot_i = 0;
  int bit_i = 0;
  logic [7:0] mosi_sh = '0;
  logic [7:0] miso_sh = '0;
  int mosi_q[$];
  int rsp_q[$];
  int rise_q[$];
  int cs_falls = 0;
  int cs_rises = 0;
  int done_cnt = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (rsp_valid) rsp_q.push_back(int'(rsp_data));
      if (done) done_cnt++;
      if (!cs_n && prev_cs) begin
        cs_falls++;
        slot_i = 0;
        bit_i = 0;
        miso_sh = resp_of(0);
        miso <= miso_sh[7];
      end
      if (cs_n && !prev_cs) cs_rises++;
      if (sclk && !prev_sclk) begin
        rise_q.push_back(cyc);
        mosi_sh = {mosi_sh[6:0], mosi};
        bit_i++;
        if (bit_i == 8) begin
          mosi_q.push_back(int'(mosi_sh));
          bit_i = 0;
        end
      end
      if (!sclk && prev_sclk) begin
        if (bit_i == 0) begin
          slot_i++;
          miso_sh = resp_of(slot_i);
        end else begin
          miso_sh = {miso_sh[6:0], 1'b0};
        end
        miso <= miso_sh[7];
      end
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    mosi_q.delete();
    rsp_q.delete();
    rise_q.delete();
    cs_falls = 0;
    cs_rises = 0;
    done_cnt = 0;
  endtask

  task automatic feed(input int n, input logic [7:0] seed, input bit gap);
    for (int i = 0; i < n; i++) begin
      cmd_data = seed + 8'(i * 13);
      cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (gap) repeat (3) @(negedge clk);
    end
  endtask

  task automatic run_txn(input int pre, input int rt, input int tx, input int rx,
                         input logic [7:0] seed, input bit gap, input bit poke);
    int tot;
    int exp_pre;
    int bad;
    tot = tx + rx;
    exp_pre = (pre < 2) ? 2 : (pre & ~1);
    clear_mon();
    @(negedge clk);
    prescale = 8'(pre);
    rate = 8'(rt);
    tx_len = LEN_W'(tx);
    rx_len = LEN_W'(rx);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      feed(tx, seed, gap);
      begin
        if (poke) begin
          repeat (30) @(negedge clk);
          tx_len = LEN_W'(5);
          rx_len = LEN_W'(5);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
      begin
        while (done_cnt == 0) @(negedge clk);
      end
    join
    repeat (4) @(negedge clk);
    chk(cs_falls == ((tot > 0) ? 1 : 0) && cs_rises == cs_falls && cs_n, "R1 cs falls", cs_falls, (tot > 0) ? 1 : 0);
    chk(mosi_q.size() == tot, "R2 slot count", mosi_q.size(), tot);
    bad = 0;
    for (int i = 0; i < mosi_q.size(); i++) begin
      if (i < tx) begin
        if (mosi_q[i] != int'(8'(seed + 8'(i * 13)))) bad++;
      end else if (mosi_q[i] != 0) bad++;
    end
    chk(bad == 0, "R4 mosi bytes (command then 0x00)", bad, 0);
    chk(rsp_q.size() == rx, "R3 response count", rsp_q.size(), rx);
    bad = 0;
    for (int i = 0; i < rsp_q.size(); i++)
      if (rsp_q[i] != int'(resp_of(tx + i))) bad++;
    chk(bad == 0, "R3 response bytes", bad, 0);
    if (tot > 0)
      chk(rise_q.size() >= 2 && (rise_q[1] - rise_q[0]) == exp_pre * (1 + rt),
          "R6 sclk period", (rise_q.size() >= 2) ? rise_q[1] - rise_q[0] : -1, exp_pre * (1 + rt));
    chk(done_cnt == 1 && !busy, "R9 done once", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    chk(cs_n && !sclk && !busy && !done && !rsp_valid && !cmd_ready, "R11 reset state",
        {cs_n, sclk, busy, done, rsp_valid, cmd_ready}, 6'b100000);

    // R7: start ignored while disabled, bus parked
    clear_mon();
    tx_len = LEN_W'(2);
    rx_len = LEN_W'(2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(cs_n && !bus_oe && !busy && done_cnt == 0 && cs_falls == 0 && !sclk && !mosi,
        "R7 disabled start ignored", {cs_n, bus_oe, busy, done_cnt[0]}, 4'b1000);

    en = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_txn(int'(VEC[v][39:32]), int'(VEC[v][31:24]), int'(VEC[v][23:16]),
              int'(VEC[v][15:8]), 8'hC3 + 8'(v * 17), VEC[v][0], VEC[v][1]);
    end

    // R10: both lengths zero -> done without chip select
    run_txn(2, 0, 0, 0, 8'h00, 1'b0, 1'b0);
    chk(cs_falls == 0 && done_cnt == 1, "R10 zero-length done without cs", cs_falls, 0);

    // R7 / R8: abandon an exchange mid response byte
    clear_mon();
    @(negedge clk);
    prescale = 8'd2;
    rate = 8'd1;
    tx_len = LEN_W'(2);
    rx_len = LEN_W'(4);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      feed(2, 8'h11, 1'b0);
    join_none
    while (rsp_q.size() < 1) @(negedge clk);
    repeat (12) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(cs_n && !bus_oe && !busy && !sclk, "R7 disable aborts", {cs_n, bus_oe, busy, sclk}, 4'b1000);
    repeat (5) @(negedge clk);
    en = 1'b1;
    repeat (40) @(negedge clk);
    chk(rsp_q.size() == 1 && done_cnt == 0 && cs_n, "R8 no partial byte after abort", rsp_q.size(), 1);
    // R8: next transaction starts clean
    run_txn(2, 0, 1, 3, 8'h77, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule